// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block holds the debug breakpoint state of a processor core: four linear-address breakpoint registers, a status word and a control word. Every byte address the core touches is presented on the check port together with the kind of access. The unit compares it against the four breakpoints and records a hit in the status word. When an armed breakpoint hits, it raises an instruction-breakpoint trap or a data-breakpoint trap.

The core reaches the debug registers through a register port. That port applies the privilege rules, the general-detect lock and the rules for indices 4 and 5. A blocked access leaves every register unchanged and reports one of three outcomes: a protection fault, a general-detect trap or an illegal-register fault. All outputs are registered, so each result appears in the cycle after the access or check that caused it. A multi-byte access is presented as one check per byte, and the status bits from those checks accumulate.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset, breakpoint registers 0 to 3 read 0, the status word reads 0xFFFF1FF0 and the control word reads 0x00000400.
- R2: Register index map: indices 0 to 3 select the breakpoint addresses, 6 selects status and 7 selects control. While `reg_dext` is low, index 4 aliases 6 and index 5 aliases 7. Read data appears on `reg_rdata` one cycle after the access.
- R3: A write to the status word changes only the bits under mask 0x0000F00F. All other bits keep their value.
- R4: A write to the control word always stores bit 10 as 1.
- R5: While `reg_dext` is high, an access to index 4 or 5 raises `fault_ill` for one cycle and changes no register.
- R6: An access with `reg_cpl` non-zero while `reg_pmode` is high raises `fault_gp` and changes nothing. This check wins over the general-detect check.
- R7: While control bit 13 is set and `resume` is low, every register access is blocked and raises `trap_gd`. With `resume` high, the access proceeds.
- R8: Access kinds are encoded on `chk_kind` as 00 fetch, 01 write and 10 read. Breakpoint n has a 4-bit field at control bits [16+4n+3:16+4n]. Its low two bits select the type: 00 matches fetches, 01 matches writes, 11 matches reads and writes, and 10 never matches.
- R9: The upper two bits of that field form a length code whose inverse masks address bits [1:0] before the compare. Code 00 compares exactly, 01 ignores bit 0 and 11 ignores bits 1:0.
- R10: A match sets status bit n even when breakpoint n's enable field (control bits [2n+1:2n]) is 00. A trap needs a non-zero enable field. No compare is made at all while control bits [7:0] are all zero.
- R11: An armed hit on a fetch pulses `trap_ibp`, and an armed hit on a read or write pulses `trap_dbp`. Both pulses come one cycle after the check.
- R12: While `abort_pend` is high, no check takes place. While `resume` is high, fetch checks are skipped but data checks still take place.
- R13: When several breakpoints match one check, all of their status bits are set. Status hit bits stay set across later checks until software writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_idx | input | 3 | Debug register index |
| reg_wdata | input | 32 | Write data |
| reg_cpl | input | 2 | Current privilege level |
| reg_pmode | input | 1 | Protected mode active |
| reg_dext | input | 1 | Debug extension enable (indices 4 and 5 become illegal) |
| resume | input | 1 | Resume flag |
| chk_en | input | 1 | Byte access check request |
| chk_addr | input | ADDR_W | Byte linear address |
| chk_kind | input | 2 | Access kind |
| abort_pend | input | 1 | Abort pending; suppresses checks |
| reg_rdata | output | 32 | Read data, registered |
| fault_gp | output | 1 | Protection fault pulse |
| fault_ill | output | 1 | Illegal register fault pulse |
| trap_gd | output | 1 | General-detect trap pulse |
| trap_ibp | output | 1 | Instruction breakpoint trap pulse |
| trap_dbp | output | 1 | Data breakpoint trap pulse |

## Verification
The assertions assume one register access or one byte check per cycle, each asserted for a single cycle. They also assume that `chk_kind` carries only the three defined encodings when a check is made. The bench drives every request for exactly one cycle and never raises `reg_en` and `chk_en` together. It changes the control word only between check sequences. It reads the status word back through the register port after each check, so hit bits are observed without looking inside the design.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        GATE_OK  = 2'b00,
        GATE_GP  = 2'b01,
        GATE_GD  = 2'b10,
        GATE_ILL = 2'b11
    } gate_e;

    localparam logic [REG_W-1:0] STAT_RST   = 32'hFFFF_1FF0;
    localparam logic [REG_W-1:0] CTRL_RST   = 32'h0000_0400;
    localparam logic [REG_W-1:0] STAT_WMASK = 32'h0000_F00F;
    localparam int CTRL_FORCE_BIT = 10;
    localparam int CTRL_GD_BIT    = 13;
    localparam int CTRL_LT_BASE   = 16;
endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [3:0]        len_type,
    input  logic [1:0]        enable,
    input  logic [ADDR_W-1:0] chk_addr,
    input  acc_kind_e         kind,
    output logic              hit,
    output logic              armed
);
    logic [ADDR_W-1:0] cmp_mask;
    logic              kind_ok;

    // Length code inverted gives the low two mask bits (R9)
    assign cmp_mask = {{(ADDR_W-2){1'b1}}, ~len_type[3:2]};

    // Type filter (R8)
    always_comb begin
        unique case (len_type[1:0])
            2'b00:   kind_ok = (kind == ACC_FETCH);
            2'b01:   kind_ok = (kind == ACC_WRITE);
            2'b11:   kind_ok = (kind == ACC_WRITE) || (kind == ACC_READ);
            default: kind_ok = 1'b0;
        endcase
    end

    assign hit   = kind_ok && ((bp_addr & cmp_mask) == (chk_addr & cmp_mask));
    assign armed = hit && (enable != 2'b00);
endmodule

// File: rtl/dbg_reg_gate.sv
module dbg_reg_gate
    import dbg_bkpt_pkg::*;
(
    input  logic [2:0] idx,
    input  logic [1:0] cpl,
    input  logic       pmode,
    input  logic       dext,
    input  logic       gd_on,
    input  logic       resume,
    output gate_e      verdict,
    output logic       sel_addr,
    output logic       sel_stat,
    output logic       sel_ctrl
);
    logic alias_idx;
    assign alias_idx = (idx[2:1] == 2'b10);

    // Privilege first (R6), then general detect (R7), then extension rule (R5)
    always_comb begin
        if (pmode && (cpl != 2'd0))      verdict = GATE_GP;
        else if (gd_on && !resume)       verdict = GATE_GD;
        else if (alias_idx && dext)      verdict = GATE_ILL;
        else                             verdict = GATE_OK;
    end

    // Index map with aliasing (R2)
    assign sel_addr = !idx[2];
    assign sel_stat = idx[2] && !idx[0];
    assign sel_ctrl = idx[2] &&  idx[0];
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    input  logic [1:0]        reg_cpl,
    input  logic              reg_pmode,
    input  logic              reg_dext,
    input  logic              resume,
    input  logic              chk_en,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        chk_kind,
    input  logic              abort_pend,
    output logic [31:0]       reg_rdata,
    output logic              fault_gp,
    output logic              fault_ill,
    output logic              trap_gd,
    output logic              trap_ibp,
    output logic              trap_dbp
);
    localparam int BP_IDX_W = $clog2(NUM_BP);

    typedef struct packed {
        logic [NUM_BP-1:0][ADDR_W-1:0] bp;
        logic [REG_W-1:0]              stat;
        logic [REG_W-1:0]              ctrl;
        logic [REG_W-1:0]              rdata;
        logic                          f_gp;
        logic                          f_ill;
        logic                          t_gd;
        logic                          t_ibp;
        logic                          t_dbp;
    } state_t;

    state_t st_d, st_q;

    acc_kind_e         kind;
    logic [NUM_BP-1:0] hit_vec, arm_vec;
    logic              chk_live;
    gate_e             verdict;
    logic              sel_addr, sel_stat, sel_ctrl;

    assign kind = acc_kind_e'(chk_kind);

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        dbg_bp_match #(.ADDR_W(ADDR_W)) match_i (
            .bp_addr  (st_q.bp[g]),
            .len_type (st_q.ctrl[CTRL_LT_BASE + 4*g +: 4]),
            .enable   (st_q.ctrl[2*g +: 2]),
            .chk_addr (chk_addr),
            .kind     (kind),
            .hit      (hit_vec[g]),
            .armed    (arm_vec[g])
        );
    end

    dbg_reg_gate gate_i (
        .idx      (reg_idx),
        .cpl      (reg_cpl),
        .pmode    (reg_pmode),
        .dext     (reg_dext),
        .gd_on    (st_q.ctrl[CTRL_GD_BIT]),
        .resume   (resume),
        .verdict  (verdict),
        .sel_addr (sel_addr),
        .sel_stat (sel_stat),
        .sel_ctrl (sel_ctrl)
    );

    // Check gating (R10, R12)
    assign chk_live = chk_en && !abort_pend && !((kind == ACC_FETCH) && resume)
                      && (st_q.ctrl[2*NUM_BP-1:0] != '0);

    always_comb begin
        st_d       = st_q;
        st_d.f_gp  = 1'b0;
        st_d.f_ill = 1'b0;
        st_d.t_gd  = 1'b0;
        st_d.t_ibp = 1'b0;
        st_d.t_dbp = 1'b0;

        if (reg_en) begin
            unique case (verdict)
                GATE_GP:  st_d.f_gp  = 1'b1;
                GATE_GD:  st_d.t_gd  = 1'b1;
                GATE_ILL: st_d.f_ill = 1'b1;
                default: begin
                    if (reg_wr) begin
                        if (sel_addr)
                            st_d.bp[reg_idx[BP_IDX_W-1:0]] = reg_wdata[ADDR_W-1:0];
                        if (sel_stat)
                            st_d.stat = (st_q.stat & ~STAT_WMASK) | (reg_wdata & STAT_WMASK);
                        if (sel_ctrl)
                            st_d.ctrl = reg_wdata | (REG_W'(1) << CTRL_FORCE_BIT);
                    end else begin
                        if (sel_addr)      st_d.rdata = REG_W'(st_q.bp[reg_idx[BP_IDX_W-1:0]]);
                        else if (sel_stat) st_d.rdata = st_q.stat;
                        else               st_d.rdata = st_q.ctrl;
                    end
                end
            endcase
        end

        // Hits accumulate after any status write in the same cycle (R13)
        if (chk_live) begin
            st_d.stat[NUM_BP-1:0] = st_d.stat[NUM_BP-1:0] | hit_vec;
            if (arm_vec != '0) begin
                if (kind == ACC_FETCH) st_d.t_ibp = 1'b1;
                else                   st_d.t_dbp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.stat  <= STAT_RST;
            st_q.ctrl  <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign fault_gp  = st_q.f_gp;
    assign fault_ill = st_q.f_ill;
    assign trap_gd   = st_q.t_gd;
    assign trap_ibp  = st_q.t_ibp;
    assign trap_dbp  = st_q.t_dbp;

    // Assertions
    p_ctrl_bit10_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl[CTRL_FORCE_BIT]);

    p_stat_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat[31:16] == 16'hFFFF) && (st_q.stat[11:4] == 8'hFF));

    p_gp_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_pmode && (reg_cpl != 2'd0)) |=> (fault_gp && !trap_gd && !fault_ill));

    p_gd_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_wr && st_q.ctrl[CTRL_GD_BIT] && !resume && !(reg_pmode && (reg_cpl != 2'd0)))
        |=> (trap_gd && $stable(st_q.ctrl)));

    p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && abort_pend) |=> (!trap_ibp && !trap_dbp));

    p_resume_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && resume && (chk_kind == 2'b00)) |=> !trap_ibp);

    p_one_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_ibp, trap_dbp}));

    p_sticky_hits_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && reg_wr) |=> ((st_q.stat[NUM_BP-1:0] & $past(st_q.stat[NUM_BP-1:0]))
                                   == $past(st_q.stat[NUM_BP-1:0])));
endmodule

// File: tb/dbg_bkpt_unit_tb_top.sv
module dbg_bkpt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 0, reg_wr = 0, reg_pmode = 0, reg_dext = 0, resume = 0;
    logic [2:0]  reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [1:0]  reg_cpl = 0;
    logic        chk_en = 0, abort_pend = 0;
    logic [31:0] chk_addr = 0;
    logic [1:0]  chk_kind = 0;
    logic [31:0] reg_rdata;
    logic        fault_gp, fault_ill, trap_gd, trap_ibp, trap_dbp;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_bkpt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_cpl(reg_cpl), .reg_pmode(reg_pmode), .reg_dext(reg_dext),
        .resume(resume), .chk_en(chk_en), .chk_addr(chk_addr), .chk_kind(chk_kind),
        .abort_pend(abort_pend), .reg_rdata(reg_rdata), .fault_gp(fault_gp),
        .fault_ill(fault_ill), .trap_gd(trap_gd), .trap_ibp(trap_ibp), .trap_dbp(trap_dbp));

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] addr;
        logic        rsm;
        logic        abt;
        logic        ibp;
        logic        dbp;
        logic [3:0]  hits;
    } vec_t;

    // Config: bp0 0x1000 fetch exact armed; bp1 0x2003 write len01 armed;
    // bp2 0x3005 rw len11 disarmed; bp3 0x2002 never-type armed
    localparam logic [31:0] CFG = 32'h2F50_0049;
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
        '{2'b00, 32'h1001, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{2'b01, 32'h2002, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010},
        '{2'b01, 32'h2003, 1'b0, 1'b0, 1'b0, 1'b1, 4'b0010},
        '{2'b10, 32'h2002, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{2'b10, 32'h3006, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{2'b01, 32'h3007, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100},
        '{2'b00, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{2'b01, 32'h2002, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000},
        '{2'b01, 32'h2002, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0010},
        '{2'b00, 32'h3004, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{2'b10, 32'h3008, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}
    };

    logic [31:0] s_rdata;
    logic s_gp, s_ill, s_gd, s_ibp, s_dbp;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_op(input logic wr, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = wr; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        s_rdata = reg_rdata; s_gp = fault_gp; s_ill = fault_ill; s_gd = trap_gd;
        reg_en = 0; reg_wr = 0;
    endtask

    task automatic chk_op(input logic [1:0] k, input logic [31:0] a, input logic r, input logic ab);
        @(negedge clk);
        chk_en = 1; chk_kind = k; chk_addr = a; resume = r; abort_pend = ab;
        @(negedge clk);
        s_ibp = trap_ibp; s_dbp = trap_dbp;
        chk_en = 0; resume = 0; abort_pend = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        for (int i = 0; i < 4; i++) begin
            reg_op(0, 3'(i), 0);
            check("R1 addr reset", s_rdata, 32'h0);
        end
        reg_op(0, 3'd6, 0); check("R1 status reset", s_rdata, 32'hFFFF_1FF0);
        reg_op(0, 3'd7, 0); check("R1 control reset", s_rdata, 32'h0000_0400);
        // R3 status write mask
        reg_op(1, 3'd6, 32'hFFFF_FFFF); reg_op(0, 3'd6, 0);
        check("R3 status set", s_rdata, 32'hFFFF_FFFF);
        reg_op(1, 3'd6, 32'h0); reg_op(0, 3'd6, 0);
        check("R3 status clear", s_rdata, 32'hFFFF_0FF0);
        // R4 control bit 10 forced
        reg_op(1, 3'd7, 32'h0); reg_op(0, 3'd7, 0);
        check("R4 ctrl force", s_rdata, 32'h0000_0400);
        // R2 aliasing
        reg_op(1, 3'd5, 32'h0000_0003); reg_op(0, 3'd7, 0);
        check("R2 alias 5->7", s_rdata, 32'h0000_0403);
        reg_op(0, 3'd4, 0);
        check("R2 alias 4->6", s_rdata, 32'hFFFF_0FF0);
        // R5 extension enable
        reg_dext = 1;
        reg_op(1, 3'd5, 32'h0); check("R5 ill fault", 32'(s_ill), 32'd1);
        reg_op(0, 3'd7, 0);     check("R5 ctrl unchanged", s_rdata, 32'h0000_0403);
        reg_dext = 0;
        // R6 privilege
        reg_cpl = 3; reg_pmode = 1;
        reg_op(1, 3'd0, 32'hDEAD); check("R6 gp fault", 32'(s_gp), 32'd1);
        reg_pmode = 0;
        reg_op(0, 3'd0, 0); check("R6 real mode ok / no write", s_rdata, 32'h0);
        check("R6 no gp in real mode", 32'(s_gp), 32'd0);
        reg_cpl = 0;
        // R7 general detect
        reg_op(1, 3'd7, 32'h0000_2000);
        reg_op(0, 3'd0, 0); check("R7 gd trap", 32'(s_gd), 32'd1);
        reg_cpl = 3; reg_pmode = 1;
        reg_op(0, 3'd0, 0);
        check("R6 gp over gd", {30'd0, s_gp, s_gd}, 32'd2);
        reg_cpl = 0; reg_pmode = 0;
        @(negedge clk); resume = 1;
        reg_op(0, 3'd7, 0); check("R7 resume passes", s_rdata, 32'h0000_2400);
        @(negedge clk); resume = 1;
        reg_op(1, 3'd7, 32'h0); resume = 0;
        reg_op(0, 3'd7, 0); check("R7 gd cleared", s_rdata, 32'h0000_0400);
        // configure breakpoints
        reg_op(1, 3'd0, 32'h1000); reg_op(1, 3'd1, 32'h2003);
        reg_op(1, 3'd2, 32'h3005); reg_op(1, 3'd3, 32'h2002);
        reg_op(0, 3'd1, 0); check("R2 addr readback", s_rdata, 32'h2003);
        reg_op(1, 3'd7, CFG);
        // Vector table: R8 R9 R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            reg_op(1, 3'd6, 32'h0);
            chk_op(VEC[v].kind, VEC[v].addr, VEC[v].rsm, VEC[v].abt);
            check($sformatf("R11 ibp vec%0d", v), 32'(s_ibp), 32'(VEC[v].ibp));
            check($sformatf("R11 dbp vec%0d", v), 32'(s_dbp), 32'(VEC[v].dbp));
            reg_op(0, 3'd6, 0);
            check($sformatf("R8/R9/R10/R12 status vec%0d", v), s_rdata,
                  32'hFFFF_0FF0 | {28'd0, VEC[v].hits});
        end
        // R13 multiple matches and stickiness
        reg_op(1, 3'd7, 32'h1F50_0049);
        reg_op(1, 3'd6, 32'h0);
        chk_op(2'b01, 32'h2002, 0, 0);
        check("R13 multi dbp", 32'(s_dbp), 32'd1);
        reg_op(0, 3'd6, 0); check("R13 multi hits", s_rdata, 32'hFFFF_0FFA);
        chk_op(2'b00, 32'h1000, 0, 0);
        reg_op(0, 3'd6, 0); check("R13 sticky", s_rdata, 32'hFFFF_0FFB);
        // R10 global gate: no enables -> no compare
        reg_op(1, 3'd7, 32'h2F50_0000);
        reg_op(1, 3'd6, 32'h0);
        chk_op(2'b00, 32'h1000, 0, 0);
        check("R10 gate no trap", 32'(s_ibp), 32'd0);
        reg_op(0, 3'd6, 0); check("R10 gate no hit", s_rdata, 32'hFFFF_0FF0);
        done = 1;
        finish_run();
    end
endmodule